// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

The block recovers bytes from a low-speed USB line pair. It runs on a clock that gives ten samples per bit time. The two line inputs first pass through a two-stage synchronizer.

While the bus is idle, the block watches the synchronized D- line for a falling edge, which is a change from J to K. After such an edge it takes one sample in the middle of the following bit. If that sample is K, the block has found the double K that closes the sync field. It then locks its sampling phase to the bit centre and starts reading data. If the sample is not K, the block opens a short window and waits in it for the next J-to-K edge. If the window closes with no edge, the block reports a sync error.

Once locked, every bit-centre sample is NRZI-decoded. Stuffed bits are removed. Bytes are assembled least significant bit first and handed out with a one-cycle strobe. A single-ended zero ends the packet, except on the first bit of a byte, where it is tolerated. A packet that carries more bytes than the buffer allows is aborted. The block is placed between the line pins and a packet layer that handles PID, CRC and addresses.

Top module: `usbrx_top`

## Requirements
- R1: After reset, data_o is 0 and valid_o, eop_o, abort_o and sync_err_o are all low.
- R2: While the line rests in J (dp_i=0, dm_i=1) with no transitions, no output strobe rises.
- R3: Data reception starts only after a J-to-K edge on D- is followed, one bit time later, by a K sample (dp_i=1, dm_i=0). After a failed check, the next J-to-K edge inside the retry window starts a new check.
- R4: If a check fails and no J-to-K edge follows within RETRY_WIN cycles, sync_err_o pulses high for exactly one cycle and no byte is delivered.
- R5: A data bit decodes as 1 when D- is unchanged from the previous bit sample and as 0 when it toggled. The previous-bit history starts as K, the final sync bit.
- R6: After six consecutive decoded 1 bits, the next bit sample is dropped and does not count as a data bit. The final decoded 1 of the sync field counts toward the six.
- R7: Each group of eight data bits forms one byte, the first received bit in bit 0. The byte appears on data_o with valid_o high for one cycle.
- R8: Both lines low on a bit sample that is a stuffed bit, or on any data bit other than bit 0 of a byte, ends the packet. eop_o pulses once, and the partial byte is discarded.
- R9: Both lines low on data bit 0 of a byte does not end the packet. That bit decodes from D- (low) like any other bit.
- R10: A packet delivers at most BUF_BYTES bytes. When one more byte completes, abort_o pulses once, that byte is not delivered, and no eop_o follows for that packet.
- R11: At most one of valid_o, eop_o, abort_o and sync_err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, BIT_CLKS cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| data_o | output | 8 | Last delivered byte |
| valid_o | output | 1 | One-cycle strobe for data_o |
| eop_o | output | 1 | One-cycle end-of-packet strobe |
| abort_o | output | 1 | One-cycle overflow abort strobe |
| sync_err_o | output | 1 | One-cycle sync search failure strobe |

## Verification
The assertions check four properties on every cycle:
- the four strobes are mutually exclusive;
- valid_o and sync_err_o are single-cycle pulses;
- every eop_o follows a sampled single-ended zero;
- the count of bytes per packet never exceeds BUF_BYTES, and an abort happens exactly when that limit has been reached.

Only the bench scenarios can show the correctness of decoded byte values. They drive NRZI-encoded and bit-stuffed packets and compare each delivered byte against an independent encoder. The same scenarios cover the tolerance of a single-ended zero on bit 0, the early end on a mid-byte single-ended zero, and both outcomes of the sync search.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_CHECK,
        HS_RETRY,
        HS_DATA
    } hunt_state_e;
endpackage

// File: rtl/usbrx_sync.sv
module usbrx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/usbrx_hunt.sv
module usbrx_hunt
    import usbrx_pkg::*;
#(
    parameter int BIT_CLKS  = 10,
    parameter int RETRY_WIN = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dp_i,
    input  logic dm_i,
    input  logic stop_i,
    output logic lock_o,
    output logic samp_o,
    output logic sync_err_o
);
    localparam int CHK_AT = BIT_CLKS + BIT_CLKS / 2;
    localparam int CMAX   = (CHK_AT > RETRY_WIN) ? CHK_AT : RETRY_WIN;
    localparam int CNT_W  = $clog2(CMAX + 1);

    typedef struct packed {
        hunt_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             dm_last;
        logic             serr;
    } hunt_regs_t;

    hunt_regs_t r_d, r_q;
    logic fall;

    always_comb begin
        r_d     = r_q;
        r_d.serr    = 1'b0;
        r_d.dm_last = dm_i;
        lock_o  = 1'b0;
        samp_o  = 1'b0;
        fall    = r_q.dm_last && !dm_i;
        case (r_q.st)
            HS_IDLE: begin
                if (fall) begin
                    r_d.st  = HS_CHECK;
                    r_d.cnt = CNT_W'(1);
                end
            end
            HS_CHECK: begin
                if (r_q.cnt == CNT_W'(CHK_AT)) begin
                    r_d.cnt = CNT_W'(1);
                    if (dp_i && !dm_i) begin
                        r_d.st = HS_DATA;
                        lock_o = 1'b1;
                    end else begin
                        r_d.st = HS_RETRY;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            HS_RETRY: begin
                if (fall) begin
                    r_d.st  = HS_CHECK;
                    r_d.cnt = CNT_W'(1);
                end else if (r_q.cnt == CNT_W'(RETRY_WIN)) begin
                    r_d.st   = HS_IDLE;
                    r_d.serr = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                if (r_q.cnt == CNT_W'(BIT_CLKS)) begin
                    samp_o  = 1'b1;
                    r_d.cnt = CNT_W'(1);
                    if (stop_i) r_d.st = HS_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: HS_IDLE, cnt: '0, dm_last: 1'b0, serr: 1'b0};
        else         r_q <= r_d;
    end

    assign sync_err_o = r_q.serr;
endmodule

// File: rtl/usbrx_deser.sv
module usbrx_deser
    import usbrx_pkg::*;
#(
    parameter int BUF_BYTES = 8,
    parameter int STUFF_RUN = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dp_i,
    input  logic              dm_i,
    input  logic              lock_i,
    input  logic              samp_i,
    output logic              stop_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              eop_o,
    output logic              abort_o
);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);
    localparam int NB_W   = $clog2(BUF_BYTES + 1);
    localparam int BIDX_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              prev_dm;
        logic [ONES_W-1:0] ones;
        logic [BIDX_W-1:0] bitn;
        logic [BYTE_W-1:0] sh;
        logic [NB_W-1:0]   nbytes;
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              eop;
        logic              ovf;
    } deser_regs_t;

    deser_regs_t r_d, r_q;
    logic se0, stuffed, dbit;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.eop   = 1'b0;
        r_d.ovf   = 1'b0;
        stop_o    = 1'b0;
        se0       = !dp_i && !dm_i;
        stuffed   = (r_q.ones == ONES_W'(STUFF_RUN));
        dbit      = (dm_i == r_q.prev_dm);
        if (lock_i) begin
            r_d.prev_dm = 1'b0;
            r_d.ones    = ONES_W'(1);
            r_d.bitn    = '0;
            r_d.nbytes  = '0;
        end else if (samp_i) begin
            if (se0 && (stuffed || r_q.bitn != '0)) begin
                r_d.eop = 1'b1;
                stop_o  = 1'b1;
            end else if (stuffed) begin
                r_d.ones    = '0;
                r_d.prev_dm = dm_i;
            end else begin
                r_d.prev_dm = dm_i;
                r_d.ones    = dbit ? r_q.ones + 1'b1 : '0;
                r_d.sh      = {dbit, r_q.sh[BYTE_W-1:1]};
                if (r_q.bitn == BIDX_W'(BYTE_W - 1)) begin
                    r_d.bitn = '0;
                    if (r_q.nbytes == NB_W'(BUF_BYTES)) begin
                        r_d.ovf = 1'b1;
                        stop_o  = 1'b1;
                    end else begin
                        r_d.data   = r_d.sh;
                        r_d.valid  = 1'b1;
                        r_d.nbytes = r_q.nbytes + 1'b1;
                    end
                end else begin
                    r_d.bitn = r_q.bitn + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign data_o  = r_q.data;
    assign valid_o = r_q.valid;
    assign eop_o   = r_q.eop;
    assign abort_o = r_q.ovf;
endmodule

// File: rtl/usbrx_top.sv
module usbrx_top
    import usbrx_pkg::*;
#(
    parameter int BIT_CLKS  = 10,
    parameter int BUF_BYTES = 8,
    parameter int RETRY_WIN = 2 * BIT_CLKS,
    parameter int STUFF_RUN = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dp_i,
    input  logic              dm_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              eop_o,
    output logic              abort_o,
    output logic              sync_err_o
);
    logic [1:0] line_s;
    logic lock, samp, stop;

    usbrx_sync #(.W(2), .STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({dp_i, dm_i}),
        .sync_o  (line_s)
    );

    usbrx_hunt #(.BIT_CLKS(BIT_CLKS), .RETRY_WIN(RETRY_WIN)) u_hunt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .dp_i       (line_s[1]),
        .dm_i       (line_s[0]),
        .stop_i     (stop),
        .lock_o     (lock),
        .samp_o     (samp),
        .sync_err_o (sync_err_o)
    );

    usbrx_deser #(.BUF_BYTES(BUF_BYTES), .STUFF_RUN(STUFF_RUN)) u_deser (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .dp_i    (line_s[1]),
        .dm_i    (line_s[0]),
        .lock_i  (lock),
        .samp_i  (samp),
        .stop_o  (stop),
        .data_o  (data_o),
        .valid_o (valid_o),
        .eop_o   (eop_o),
        .abort_o (abort_o)
    );
endmodule

// File: rtl/usbrx_chk.sv
module usbrx_chk #(
    parameter int BUF_BYTES = 8
) (
    input logic clk_i,
    input logic rst_ni,
    input logic dp_i,
    input logic dm_i,
    input logic valid_o,
    input logic eop_o,
    input logic abort_o,
    input logic sync_err_o
);
    localparam int PC_W = $clog2(BUF_BYTES + 1) + 1;
    logic [PC_W-1:0] pkt_d, pkt_q;

    always_comb begin
        pkt_d = pkt_q;
        if (eop_o || abort_o) pkt_d = '0;
        else if (valid_o)     pkt_d = pkt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pkt_q <= '0;
        else         pkt_q <= pkt_d;
    end

    assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({valid_o, eop_o, abort_o, sync_err_o}));

    assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    assert_serr_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_err_o |=> !sync_err_o);

    assert_eop_on_se0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_o |-> ($past(dp_i, 3) == 1'b0 && $past(dm_i, 3) == 1'b0));

    assert_byte_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_q <= PC_W'(BUF_BYTES));

    assert_abort_at_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> (pkt_q == PC_W'(BUF_BYTES)));
endmodule

bind usbrx_top usbrx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dp_i       (dp_i),
    .dm_i       (dm_i),
    .valid_o    (valid_o),
    .eop_o      (eop_o),
    .abort_o    (abort_o),
    .sync_err_o (sync_err_o)
);

// File: tb/usbrx_top_tb.sv
`timescale 1ns/1ps
module usbrx_top_tb;
    localparam int BITC = 10;
    localparam int BUF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp = 1'b0, dm = 1'b1;
    logic [7:0] data;
    logic valid, eop, abort_f, serr;

    always #10 clk = ~clk;

    usbrx_top #(.BIT_CLKS(BITC), .BUF_BYTES(BUF)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
        .data_o(data), .valid_o(valid), .eop_o(eop),
        .abort_o(abort_f), .sync_err_o(serr)
    );

    int n_chk = 0, n_fail = 0;
    int n_valid = 0, n_eop = 0, n_abort = 0, n_serr = 0;
    bit done = 0;
    bit monitor_on = 0;
    string cur_req = "R7";
    logic [7:0] exp_q[$];
    logic [7:0] pkt_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (monitor_on) begin
            if (valid) begin
                n_valid++;
                if (exp_q.size() == 0) check(0, cur_req, int'(data), -1);
                else begin
                    check(data == exp_q[0], cur_req, int'(data), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
            end
            if (eop)     n_eop++;
            if (abort_f) n_abort++;
            if (serr)    n_serr++;
        end
    end

    task automatic clear_counts();
        n_valid = 0; n_eop = 0; n_abort = 0; n_serr = 0;
    endtask

    task automatic drive(input logic p, input logic m);
        dp = p; dm = m;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send_lvl(input bit l);  // l = D- level, 1 = J
        drive(!l, l);
    endtask

    task automatic send_packet(input int limit, input int glitch_idx);
        bit lvl;
        int ones, total;
        logic [7:0] b;
        bit bv;
        exp_q.delete();
        send_lvl(1); send_lvl(1);
        send_lvl(0); send_lvl(1); send_lvl(0); send_lvl(1);
        send_lvl(0); send_lvl(1); send_lvl(0); send_lvl(0);
        lvl = 0; ones = 1; total = 0;
        for (int i = 0; i < pkt_q.size(); i++) begin
            if (limit >= 0 && total >= limit) break;
            b = pkt_q[i];
            if (i == glitch_idx) b[0] = (lvl == 1'b0);
            if (i < BUF && (limit < 0 || total + 8 <= limit)) exp_q.push_back(b);
            for (int j = 0; j < 8; j++) begin
                if (limit >= 0 && total >= limit) break;
                bv = b[j];
                if (!bv) lvl = !lvl;
                if (i == glitch_idx && j == 0) drive(0, 0);
                else send_lvl(lvl);
                ones = bv ? ones + 1 : 0;
                if (ones == 6) begin
                    lvl = !lvl;
                    send_lvl(lvl);
                    ones = 0;
                end
                total++;
            end
        end
        drive(0, 0); drive(0, 0);
        repeat (6) send_lvl(1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(data == 8'h00 && !valid && !eop && !abort_f && !serr, "R1",
              int'({data, valid, eop, abort_f, serr}), 0);
        rst_n = 1'b1;
        monitor_on = 1;

        // R2: idle J produces nothing
        clear_counts();
        repeat (30) send_lvl(1);
        check(n_valid + n_eop + n_abort + n_serr == 0, "R2",
              n_valid + n_eop + n_abort + n_serr, 0);

        // R5 R7 R3: plain packet
        cur_req = "R5";
        clear_counts();
        pkt_q = '{8'hA5, 8'h3C, 8'h81};
        send_packet(-1, -1);
        check(n_valid == 3, "R7", n_valid, 3);
        check(n_eop == 1, "R8", n_eop, 1);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);

        // R6: bit stuffing
        cur_req = "R6";
        clear_counts();
        pkt_q = '{8'hFF, 8'hFF, 8'h7E, 8'h3F};
        send_packet(-1, -1);
        check(n_valid == 4, "R6", n_valid, 4);
        check(n_eop == 1, "R6", n_eop, 1);

        // R9: SE0 on bit 0 tolerated
        cur_req = "R9";
        clear_counts();
        pkt_q = '{8'h5A, 8'hC3, 8'h96};
        send_packet(-1, 1);
        check(n_valid == 3, "R9", n_valid, 3);
        check(n_eop == 1, "R9", n_eop, 1);

        // R8: SE0 on bit 3 of third byte ends packet early
        cur_req = "R8";
        clear_counts();
        pkt_q = '{8'h12, 8'h34, 8'h56};
        send_packet(19, -1);
        check(n_valid == 2, "R8", n_valid, 2);
        check(n_eop == 1, "R8", n_eop, 1);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);

        // R10: overflow
        cur_req = "R10";
        clear_counts();
        pkt_q = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'hEE};
        send_packet(-1, -1);
        check(n_valid == BUF, "R10", n_valid, BUF);
        check(n_abort == 1, "R10", n_abort, 1);
        check(n_eop == 0, "R10", n_eop, 0);
        repeat (6) send_lvl(1);

        // R4: single K then idle
        cur_req = "R4";
        clear_counts();
        send_lvl(1); send_lvl(0);
        repeat (8) send_lvl(1);
        check(n_serr == 1, "R4", n_serr, 1);
        check(n_valid == 0, "R4", n_valid, 0);

        // R3: two failed checks chained by retry give one error, no data
        cur_req = "R3";
        clear_counts();
        send_lvl(0); send_lvl(1); send_lvl(0); send_lvl(1);
        repeat (8) send_lvl(1);
        check(n_serr == 1, "R3", n_serr, 1);
        check(n_valid + n_eop == 0, "R3", n_valid + n_eop, 0);

        // R11: recovery after errors, with a clean packet
        cur_req = "R11";
        clear_counts();
        pkt_q = '{8'h00, 8'hFE};
        send_packet(-1, -1);
        check(n_valid == 2 && n_eop == 1 && n_abort == 0 && n_serr == 0, "R11",
              n_valid * 8 + n_eop * 4 + n_abort * 2 + n_serr, 2 * 8 + 4);

        done = 1;
        summary();
        $finish;
    end
endmodule